// File: doc/BRIEF.md
# Register/Memory Increment Execution Unit

This unit carries out a single kind of instruction: it adds one to an 8-bit operand. The operand comes from a 3-bit selector. Seven of the eight codes name a byte in a small internal register file. The eighth names the memory byte whose 16-bit address is held in a pair of those registers. A register operand finishes in the opcode fetch machine cycle. A memory operand runs a read-modify-write: a memory read and then a memory write follow the fetch, on a simple request/ready port.

Each completed instruction updates a status byte from the new value. Sign, zero, auxiliary carry and parity are recomputed, and carry is left exactly as it was. The new value is presented on `result`, and the number of T-states used is presented on `tstates`. Each T-state is one clock. Register contents and the status byte start from parameter values at reset.

Top module: `incr_exec_unit`

## Requirements
- R1: The selector `op_sel` maps 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 7=A to internal registers. Code 6 selects the memory byte at address {H,L}, with H as the high byte.
- R2: The selected operand is replaced by operand+1 modulo 256, and the same value appears on `result` while `done` is high. For example, a memory byte 05h at 4050h becomes 06h, and FFh becomes 00h.
- R3: Bit 0 of `flags` (carry) never changes after reset.
- R4: On completion, `flags` bit 7 equals result bit 7. Bit 6 is 1 when the result is 00h. Bit 4 is 1 when the low nibble wrapped from Fh to 0h. Bit 2 is 1 when the result has an even number of ones. Bits 5, 3 and 1 keep their values.
- R5: The memory form runs three cycles in this order: a fetch of 4 T-states, a read with `mem_rd` high at address {H,L}, and a write with `mem_wr` high carrying the result. With `mem_ready` always high it takes 10 T-states, and `mem_rd` and `mem_wr` are never high together.
- R6: A register form takes 4 T-states and raises neither `mem_rd` nor `mem_wr`.
- R7: In the second T-state of a read or write, each clock with `mem_ready` low adds one T-state to the count.
- R8: A `start` pulse while `busy` is high is ignored. It has no effect on any register, on memory or on the running instruction.
- R9: `done` is a one-clock pulse. A `start` given in the `done` clock is accepted and sees the value just written.
- R10: After reset, `busy`, `done`, `result` and `tstates` are 0, and `flags` equals FLAG_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (taken when idle) |
| op_sel | input | 3 | Operand selector code |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Incremented value of the last instruction |
| flags | output | 8 | Status byte |
| tstates | output | 6 | T-states used by the last instruction |
| mem_addr | output | 16 | Memory address, {H,L} |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_ready | input | 1 | Memory transfer complete |

## Verification
Two functions can meet in one clock. The first is the write-back and completion pulse of one instruction. The second is the acceptance of the next `start`. The bench issues an increment of C that wraps FFh to 00h. It then drives the next `start` for C in the very clock `done` is high, and expects 01h with odd-parity flags after 4 T-states. A second overlap, a `start` arriving mid-way through a memory read-modify-write, is judged by the unchanged T-state count and memory result, and by the later value of the register it named.

// File: rtl/incr_pkg.sv
package incr_pkg;
  localparam int DW = 8;
  localparam int SELW = 3;
  localparam logic [SELW-1:0] MEM_CODE = 3'd6;
  localparam int F_S = 7;
  localparam int F_Z = 6;
  localparam int F_AC = 4;
  localparam int F_P = 2;
  localparam int F_CY = 0;

  typedef enum logic [3:0] {
    ST_IDLE, ST_F1, ST_F2, ST_F3, ST_F4,
    ST_R1, ST_R2, ST_R3, ST_W1, ST_W2, ST_W3
  } seq_state_t;

  function automatic logic [DW-1:0] incr_value(input logic [DW-1:0] opnd);
    return opnd + 1'b1;
  endfunction

  function automatic logic [DW-1:0] incr_flags(input logic [DW-1:0] old,
                                               input logic [DW-1:0] opnd,
                                               input logic [DW-1:0] res);
    logic [DW-1:0] f;
    f = old;
    f[F_S] = res[DW-1];
    f[F_Z] = (res == '0);
    f[F_AC] = (opnd[3:0] == 4'hF);
    f[F_P] = ~(^res);
    return f;
  endfunction
endpackage

// File: rtl/incr_regfile.sv
module incr_regfile
  import incr_pkg::*;
#(
  parameter int NREG = 8,
  parameter logic [NREG*DW-1:0] REG_INIT = '0,
  parameter int H_IDX = 4,
  parameter int L_IDX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] rd_sel,
  output logic [DW-1:0]   rd_data,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [DW-1:0]   wr_data,
  output logic [2*DW-1:0] ptr
);
  logic [DW-1:0] rf [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= REG_INIT[i*DW +: DW];
    end else if (wr_en) begin
      rf[wr_sel] <= wr_data;
    end
  end

  assign rd_data = rf[rd_sel];
  assign ptr = {rf[H_IDX], rf[L_IDX]};

  // R1: the memory code never reaches the register write port
  p_no_mem_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_sel != MEM_CODE);
endmodule

// File: rtl/incr_alu.sv
module incr_alu
  import incr_pkg::*;
(
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] flags_in,
  output logic [DW-1:0] res,
  output logic [DW-1:0] flags_out,
  output logic          aux_wrap
);
  always_comb begin
    res = incr_value(opnd);
    flags_out = incr_flags(flags_in, opnd, res);
    aux_wrap = flags_out[F_AC];
  end

  // R4: a nibble wrap always leaves a zero low nibble
  always_comb begin
    p_aux_nibble_r4: assert (!aux_wrap || res[3:0] == 4'h0);
  end
endmodule

// File: rtl/incr_seq.sv
module incr_seq
  import incr_pkg::*;
#(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_mem,
  input  logic          mem_ready,
  output logic          busy,
  output logic          ev_take,
  output logic          ev_reg_commit,
  output logic          ev_capture,
  output logic          ev_modify,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          done,
  output logic [TW-1:0] tstates
);
  localparam logic [TW-1:0] TMAX = '1;
  seq_state_t st, st_nx;
  logic [TW-1:0] tcnt;
  logic finish;

  assign busy = (st != ST_IDLE);
  assign ev_take = (st == ST_IDLE) && start;
  assign ev_reg_commit = (st == ST_F4) && !is_mem;
  assign ev_capture = (st == ST_R2) && mem_ready;
  assign ev_modify = (st == ST_R3);
  assign mem_rd = (st == ST_R1) || (st == ST_R2);
  assign mem_wr = (st == ST_W1) || (st == ST_W2);
  assign finish = ev_reg_commit || (st == ST_W3);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (start) st_nx = ST_F1;
      ST_F1:   st_nx = ST_F2;
      ST_F2:   st_nx = ST_F3;
      ST_F3:   st_nx = ST_F4;
      ST_F4:   st_nx = is_mem ? ST_R1 : ST_IDLE;
      ST_R1:   st_nx = ST_R2;
      ST_R2:   if (mem_ready) st_nx = ST_R3;
      ST_R3:   st_nx = ST_W1;
      ST_W1:   st_nx = ST_W2;
      ST_W2:   if (mem_ready) st_nx = ST_W3;
      ST_W3:   st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      tcnt <= '0;
      tstates <= '0;
      done <= 1'b0;
    end else begin
      st <= st_nx;
      done <= finish;
      if (ev_take) tcnt <= TW'(1);
      else if (busy && tcnt != TMAX) tcnt <= tcnt + 1'b1;
      if (finish) tstates <= tcnt;
    end
  end

  // R5: read and write requests are exclusive
  p_bus_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R6: a register operand never touches the bus
  p_reg_no_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_mem) |-> (!mem_rd && !mem_wr));
  // R5: a write never follows directly on a read request
  p_read_before_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) |-> !$past(mem_rd));
  // R9: done lasts one clock
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/incr_exec_unit.sv
module incr_exec_unit
  import incr_pkg::*;
#(
  parameter int TW = 6,
  parameter logic [8*DW-1:0] REG_INIT = 64'h00_00_50_40_7F_0F_FF_05,
  parameter logic [DW-1:0] FLAG_INIT = 8'h01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      op_sel,
  output logic            busy,
  output logic            done,
  output logic [7:0]      result,
  output logic [7:0]      flags,
  output logic [TW-1:0]   tstates,
  output logic [15:0]     mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  input  logic            mem_ready
);
  logic [SELW-1:0] op_q;
  logic [DW-1:0] mem_byte_q, rf_rd, opnd, alu_res, alu_flags;
  logic is_mem, ev_take, ev_reg_commit, ev_capture, ev_modify, aux_wrap;

  assign is_mem = (op_q == MEM_CODE);
  assign opnd = is_mem ? mem_byte_q : rf_rd;
  assign mem_wdata = mem_byte_q;

  incr_seq #(.TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .is_mem(is_mem),
    .mem_ready(mem_ready), .busy(busy), .ev_take(ev_take),
    .ev_reg_commit(ev_reg_commit), .ev_capture(ev_capture),
    .ev_modify(ev_modify), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .done(done), .tstates(tstates)
  );

  incr_regfile #(.NREG(8), .REG_INIT(REG_INIT)) u_rf (
    .clk(clk), .rst_n(rst_n), .rd_sel(op_q), .rd_data(rf_rd),
    .wr_en(ev_reg_commit), .wr_sel(op_q), .wr_data(alu_res),
    .ptr(mem_addr)
  );

  incr_alu u_alu (
    .opnd(opnd), .flags_in(flags), .res(alu_res),
    .flags_out(alu_flags), .aux_wrap(aux_wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= '0;
      mem_byte_q <= '0;
      result <= '0;
      flags <= FLAG_INIT;
    end else begin
      if (ev_take) op_q <= op_sel;
      if (ev_capture) mem_byte_q <= mem_rdata;
      if (ev_modify) mem_byte_q <= alu_res;
      if (ev_reg_commit || ev_modify) begin
        result <= alu_res;
        flags <= alu_flags;
      end
    end
  end

  // R3: carry bit is never altered
  p_carry_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(flags[F_CY]));
  // R4: zero flag agrees with the presented result at completion
  p_zero_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flags[F_Z] == (result == '0));
  // R8: a start while busy leaves the selected operand alone
  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(op_q));
  // R2: the write carries the value presented as result
  p_write_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_wdata == result);
endmodule

// File: tb/incr_exec_unit_test.sv
module incr_exec_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op_sel = '0;
  logic busy, done, mem_rd, mem_wr, mem_ready;
  logic [7:0] result, flags, mem_wdata, mem_rdata;
  logic [5:0] tstates;
  logic [15:0] mem_addr;

  int total = 0;
  int bad = 0;
  logic [7:0] bmem [256];
  logic [7:0] mrf [8];
  logic [7:0] mflags;
  int wait_cfg = 0;
  int act_cnt = 0;
  int rd_cycles = 0;
  int wr_cycles = 0;
  logic [15:0] last_wr_addr = '0;
  logic [15:0] last_rd_addr = '0;

  always #5 clk = ~clk;

  incr_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .busy(busy), .done(done), .result(result), .flags(flags),
    .tstates(tstates), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  assign mem_rdata = bmem[mem_addr[7:0]];

  initial mem_ready = 1'b0;
  always @(negedge clk) begin
    if (mem_rd || mem_wr) begin
      mem_ready = (act_cnt >= wait_cfg);
      act_cnt = act_cnt + 1;
    end else begin
      mem_ready = 1'b0;
      act_cnt = 0;
    end
  end

  always @(posedge clk) begin
    if (mem_rd) begin
      rd_cycles <= rd_cycles + 1;
      last_rd_addr <= mem_addr;
    end
    if (mem_wr) wr_cycles <= wr_cycles + 1;
    if (mem_wr && mem_ready) begin
      bmem[mem_addr[7:0]] <= mem_wdata;
      last_wr_addr <= mem_addr;
    end
  end

  function automatic logic [7:0] exp_flags(input logic [7:0] old, input logic [7:0] v);
    logic [7:0] f;
    int ones;
    f = old;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(v[i]);
    f[7] = v[7];
    f[6] = (v == 8'h00);
    f[4] = (v[3:0] == 4'h0);
    f[2] = (ones % 2 == 0);
    return f;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // start at the current negedge; optional intruding start at negedge 'intr'
  task automatic run_inc(input logic [2:0] code, input int waits, input int intr, input string tag);
    logic [7:0] opv, expv;
    logic [15:0] addr;
    int rd0, wr0, extra, guard;
    bit seen;
    addr = {mrf[4], mrf[5]};
    opv = (code == 3'd6) ? bmem[addr[7:0]] : mrf[code];
    expv = opv + 8'd1;
    wait_cfg = waits;
    rd0 = rd_cycles;
    wr0 = wr_cycles;
    extra = (waits > 1) ? waits - 1 : 0;
    start = 1'b1;
    op_sel = code;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    guard = 0;
    while (!seen && guard < 200) begin
      if (guard == intr) begin
        start = 1'b1;
        op_sel = 3'd0;
      end else begin
        start = 1'b0;
      end
      if (done) seen = 1;
      else @(negedge clk);
      guard++;
    end
    start = 1'b0;
    chk({tag, " R9 done seen"}, 32'(seen), 32'd1);
    chk({tag, " R2 result"}, 32'(result), 32'(expv));
    mflags = exp_flags(mflags, expv);
    chk({tag, " R4 flags"}, 32'(flags), 32'(mflags));
    chk({tag, " R3 carry"}, 32'(flags[0]), 32'd1);
    if (code == 3'd6) begin
      chk({tag, " R5 tstates"}, 32'(tstates), 32'(10 + 2 * extra));
      chk({tag, " R2 memory byte"}, 32'(bmem[addr[7:0]]), 32'(expv));
      chk({tag, " R1 write address"}, 32'(last_wr_addr), 32'(addr));
      chk({tag, " R1 read address"}, 32'(last_rd_addr), 32'(addr));
      chk({tag, " R7 read cycles"}, 32'(rd_cycles - rd0), 32'(2 + extra));
      chk({tag, " R7 write cycles"}, 32'(wr_cycles - wr0), 32'(2 + extra));
    end else begin
      mrf[code] = expv;
      chk({tag, " R6 tstates"}, 32'(tstates), 32'd4);
      chk({tag, " R6 no bus"}, 32'((rd_cycles - rd0) + (wr_cycles - wr0)), 32'd0);
    end
  endtask

  task automatic t_reset();
    chk("R10 busy", 32'(busy), 32'd0);
    chk("R10 done", 32'(done), 32'd0);
    chk("R10 result", 32'(result), 32'd0);
    chk("R10 flags", 32'(flags), 32'h01);
    chk("R10 tstates", 32'(tstates), 32'd0);
    chk("R1 pointer after reset", 32'(mem_addr), 32'h4050);
  endtask

  task automatic t_mem_basic();
    run_inc(3'd6, 0, -1, "mem 4050");
    chk("R2 4050h holds 06h", 32'(bmem[8'h50]), 32'h06);
    @(negedge clk);
    chk("R9 done one clock", 32'(done), 32'd0);
  endtask

  task automatic t_busy_start();
    run_inc(3'd6, 0, 3, "busy start");
    chk("R8 still 10 T", 32'(tstates), 32'd10);
    @(negedge clk);
    chk("R8 no extra instruction", 32'(busy), 32'd0);
    run_inc(3'd0, 0, -1, "R8 B untouched");
  endtask

  task automatic t_regs();
    run_inc(3'd1, 0, -1, "C wrap");
    chk("R2 wrap zero", 32'(result), 32'h00);
    run_inc(3'd1, 0, -1, "C b2b");
    run_inc(3'd2, 0, -1, "D nibble");
    run_inc(3'd3, 0, -1, "E sign");
    run_inc(3'd7, 0, -1, "A");
    run_inc(3'd4, 0, -1, "H");
    run_inc(3'd5, 0, -1, "L");
    chk("R1 pointer moved", 32'(mem_addr), 32'h4151);
  endtask

  task automatic t_wait_states();
    @(negedge clk);
    run_inc(3'd6, 3, -1, "mem waits");
    chk("R7 14 T", 32'(tstates), 32'd14);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'(i) ^ 8'h5A;
    bmem[8'h50] = 8'h05;
    bmem[8'h51] = 8'hFF;
    mrf[0] = 8'h05; mrf[1] = 8'hFF; mrf[2] = 8'h0F; mrf[3] = 8'h7F;
    mrf[4] = 8'h40; mrf[5] = 8'h50; mrf[6] = 8'h00; mrf[7] = 8'h00;
    mflags = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mem_basic();
    t_busy_start();
    t_regs();
    t_wait_states();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule